// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. It watches five request inputs: a non-maskable input, three maskable restart inputs (called high, middle and low here) and a general external request line. Each input first passes through a synchronizer. The non-maskable input must rise and then stay high to be taken. The high restart input is caught by a sticky edge latch. The middle and low restart inputs, and the external line, are taken on level.

A global enable flip-flop and three mask bits gate the maskable sources. The core changes them through a mask-write port and reads them back, together with the pending state, through a combinational read port. It asks for a decision by pulsing `instr_boundary` at the end of each instruction. On the next cycle the block presents exactly one result. For a vectored source this is a one-cycle `req_valid` pulse with a fixed 16-bit vector. For the external line it is a one-cycle `intr_ack` pulse, so that outside hardware can place a restart opcode on the bus. Accepting any maskable source clears the global enable. Saving the return address and jumping to the vector are left to the core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Reset clears the global enable, the edge latch and serial out, and sets all three masks. With `serial_in` low, `mask_rdata` then reads 0x07.
- R2: The `mask_rdata` bits are: bit 7 `serial_in`, bit 6 the high-source edge latch, bit 5 the synchronized middle input, bit 4 the synchronized low input, bit 3 the global enable, and bits 2..0 the masks of the high, middle and low sources (1 = masked). Pending bits show even while a source is masked.
- R3: A mask write with bit 3 = 1 loads bits 2..0 into the masks (bit 2 high, bit 1 middle, bit 0 low). With bit 3 = 0 the masks keep their values.
- R4: A mask write with bit 6 = 1 loads `serial_out` from bit 7. With bit 6 = 0, `serial_out` keeps its value.
- R5: A rising edge on the high input sets the edge latch, even while that source is masked. The latch stays set after the pin falls. It is cleared by servicing that source or by a mask write with bit 4 = 1. If a new edge meets a bit-4 clear in the same cycle, the latch stays set.
- R6: The non-maskable source is taken regardless of the enable and the masks. It needs a rising edge followed by a high level. After it is serviced it is not taken again until the pin falls and rises again. A fall before service cancels it.
- R7: The vectors are fixed: non-maskable 0x0024, high 0x003C, middle 0x0034, low 0x002C. They appear on `req_vector` with a one-cycle `req_valid` in the cycle after the boundary pulse.
- R8: The middle and low sources are taken only while their synchronized pin is high, the source is unmasked and the global enable is set.
- R9: Priority is non-maskable, then high, then middle, then low, then the external line. Each boundary yields at most one result, and `req_valid` and `intr_ack` are never high together.
- R10: Accepting a maskable source or the external line clears the global enable. Accepting the non-maskable source leaves it unchanged. If acceptance and `en_set` fall in the same cycle, the enable ends cleared.
- R11: `en_set` sets the global enable on the next clock edge.
- R12: When the external line is high and the enable is set, a boundary produces a one-cycle `intr_ack` with no `req_valid`.
- R13: With no `instr_boundary` pulse, nothing is accepted. Pending state stays as it is and no result pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request input |
| irq_hi_pin | input | 1 | High-priority restart input, edge latched |
| irq_mid_pin | input | 1 | Middle restart input, level |
| irq_lo_pin | input | 1 | Low restart input, level |
| ext_irq_pin | input | 1 | External request line, level |
| instr_boundary | input | 1 | Core is at an instruction boundary; arbitrate now |
| en_set | input | 1 | Set the global enable |
| mask_wr | input | 1 | Mask-write strobe |
| mask_wdata | input | 8 | Mask-write data |
| serial_in | input | 1 | Serial input bit, shown in read data |
| mask_rdata | output | 8 | Read-mask value |
| serial_out | output | 1 | Serial output bit |
| req_valid | output | 1 | Vectored request pulse |
| req_vector | output | 16 | Vector address of the accepted source |
| intr_ack | output | 1 | Acknowledge pulse for the external line |

## Verification
Two pairs of operations can land on the same clock edge, and the bench provokes both on purpose. In the first, a rising edge of the high input reaches the latch in exactly the cycle that a mask write with the clear bit arrives; the read port must then still show the latch set. In the second, `en_set` is driven in the same cycle as a boundary that accepts the high source; the bench checks that the vector comes out and that the enable then reads cleared. A scoreboard predicts the result of every boundary, including the priority order when several sources are pending together.

// File: rtl/irq_vec_pkg.sv
// Package: shared constants for the vectored interrupt controller.
// Assumes source indices double as priority rank (0 = highest).
package irq_vec_pkg;

    localparam int NSRC  = 5;
    localparam int VEC_W = 16;
    localparam int NMASK = 3;

    // Source index; lower value wins arbitration.
    typedef enum logic [2:0] {
        SRC_NMI = 3'd0,
        SRC_HI  = 3'd1,
        SRC_MID = 3'd2,
        SRC_LO  = 3'd3,
        SRC_EXT = 3'd4
    } src_e;

    localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_HI  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_MID = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO  = 16'h002C;

    // Mask-write field positions.
    localparam int MW_SOD   = 7;
    localparam int MW_SOE   = 6;
    localparam int MW_CLRHI = 4;
    localparam int MW_MLD   = 3;

    // Vector for a source index; the external line has none.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        case (idx)
            0:       vec_of = VEC_NMI;
            1:       vec_of = VEC_HI;
            2:       vec_of = VEC_MID;
            3:       vec_of = VEC_LO;
            default: vec_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
// Module: irq_pin_sync
// Brings W asynchronous request pins into the clock domain through a
// STAGES-deep flop chain per pin. Assumes STAGES >= 1; all chains reset low.
module irq_pin_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_lvl
);

    for (genvar g = 0; g < W; g++) begin : g_pin
        logic [STAGES-1:0] chain;

        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2+1:0] << 1} | {{(STAGES-1){1'b0}}, pin_raw[g]};
        end

        assign pin_lvl[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/irq_pend_latch.sv
// Module: irq_pend_latch
// Holds the edge-qualified pending state: the arm flop of the non-maskable
// source (set on rise, dropped on fall or service) and the sticky edge latch
// of the high restart source (set on rise, cleared on service or by a
// software clear; a same-cycle edge beats the clear).
// Assumes inputs are already synchronized.
module irq_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_lvl,
    input  logic hi_lvl,
    input  logic take_nmi,
    input  logic take_hi,
    input  logic sw_clr_hi,
    output logic nmi_act,
    output logic hi_pend
);

    logic nmi_prev;
    logic hi_prev;
    logic nmi_arm;
    logic nmi_rise;
    logic nmi_fall;
    logic hi_rise;

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            hi_prev  <= 1'b0;
        end else begin
            nmi_prev <= nmi_lvl;
            hi_prev  <= hi_lvl;
        end
    end

    assign nmi_rise = nmi_lvl & ~nmi_prev;
    assign nmi_fall = ~nmi_lvl & nmi_prev;
    assign hi_rise  = hi_lvl & ~hi_prev;

    // Non-maskable arm: fall cancels, rise arms, service disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)        nmi_arm <= 1'b0;
        else if (nmi_fall) nmi_arm <= 1'b0;
        else if (nmi_rise) nmi_arm <= 1'b1;
        else if (take_nmi) nmi_arm <= 1'b0;
    end

    // Sticky high-source latch: a new edge wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hi_pend <= 1'b0;
        else if (hi_rise)               hi_pend <= 1'b1;
        else if (take_hi || sw_clr_hi)  hi_pend <= 1'b0;
    end

    assign nmi_act = nmi_arm & nmi_lvl;

endmodule

// File: rtl/irq_mask_regs.sv
// Module: irq_mask_regs
// Global enable flop, per-source mask bits and the serial output bit,
// updated by the mask-write port, the set-enable input and acceptance.
// Assumes acceptance of a maskable source outranks a same-cycle set-enable.
module irq_mask_regs
    import irq_vec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [7:0]       mask_wdata,
    input  logic             en_set,
    input  logic             take_maskable,
    output logic             glb_en,
    output logic [NMASK-1:0] mask_q,
    output logic             sod_q,
    output logic             sw_clr_hi
);

    logic wdata_unused;
    assign wdata_unused = mask_wdata[5];

    // Global enable: acceptance clears, set-enable sets.
    always_ff @(posedge clk) begin
        if (!rst_n)             glb_en <= 1'b0;
        else if (take_maskable) glb_en <= 1'b0;
        else if (en_set)        glb_en <= 1'b1;
    end

    // Masks load only when the mask-load bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '1;
        else if (mask_wr && mask_wdata[MW_MLD]) mask_q <= mask_wdata[NMASK-1:0];
    end

    // Serial output loads only when its enable bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                             sod_q <= 1'b0;
        else if (mask_wr && mask_wdata[MW_SOE]) sod_q <= mask_wdata[MW_SOD];
    end

    assign sw_clr_hi = mask_wr & mask_wdata[MW_CLRHI];

endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Fixed-priority pick among N candidates at an instruction boundary
// (index 0 highest). Produces one-hot take strobes in the same cycle and
// registers the result: a vector pulse or an acknowledge for the external
// line. Assumes candidates are already gated by enable and masks.
module irq_arbiter
    import irq_vec_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic [N-1:0]     cand,
    output logic [N-1:0]     take,
    output logic             req_valid,
    output logic [VEC_W-1:0] req_vector,
    output logic             intr_ack
);

    localparam logic [N-1:0] EXT_BIT  = N'(1) << SRC_EXT;
    localparam logic [N-1:0] VEC_BITS = ~EXT_BIT;

    logic             hit;
    logic [VEC_W-1:0] sel_vec;
    logic             take_vec;

    // Find the lowest-index candidate and strobe it at a boundary.
    always_comb begin
        take    = '0;
        hit     = 1'b0;
        sel_vec = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && !hit) begin
                hit     = 1'b1;
                take[i] = boundary;
                sel_vec = vec_of(i);
            end
        end
    end

    assign take_vec = |(take & VEC_BITS);

    // Register the single result of this boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            req_vector <= '0;
            intr_ack   <= 1'b0;
        end else begin
            req_valid  <= take_vec;
            req_vector <= take_vec ? sel_vec : '0;
            intr_ack   <= |(take & EXT_BIT);
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: irq_vector_ctrl (top)
// Interrupt front end: synchronizes five request pins, keeps edge and
// level pending state, gates maskable sources with the enable and masks,
// and arbitrates at each instruction boundary. Assumes the core pulses
// instr_boundary for one cycle per instruction end.
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic             irq_hi_pin,
    input  logic             irq_mid_pin,
    input  logic             irq_lo_pin,
    input  logic             ext_irq_pin,
    input  logic             instr_boundary,
    input  logic             en_set,
    input  logic             mask_wr,
    input  logic [7:0]       mask_wdata,
    input  logic             serial_in,
    output logic [7:0]       mask_rdata,
    output logic             serial_out,
    output logic             req_valid,
    output logic [VEC_W-1:0] req_vector,
    output logic             intr_ack
);

    logic [NSRC-1:0]  pin_raw;
    logic [NSRC-1:0]  lvl;
    logic [NSRC-1:0]  cand;
    logic [NSRC-1:0]  take;
    logic             nmi_act;
    logic             hi_pend;
    logic             glb_en;
    logic [NMASK-1:0] mask_q;
    logic             sw_clr_hi;
    logic             take_maskable;

    assign pin_raw = {ext_irq_pin, irq_lo_pin, irq_mid_pin, irq_hi_pin, nmi_pin};

    irq_pin_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_raw),
        .pin_lvl (lvl)
    );

    irq_pend_latch u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_lvl   (lvl[SRC_NMI]),
        .hi_lvl    (lvl[SRC_HI]),
        .take_nmi  (take[SRC_NMI]),
        .take_hi   (take[SRC_HI]),
        .sw_clr_hi (sw_clr_hi),
        .nmi_act   (nmi_act),
        .hi_pend   (hi_pend)
    );

    irq_mask_regs u_mask (
        .clk           (clk),
        .rst_n         (rst_n),
        .mask_wr       (mask_wr),
        .mask_wdata    (mask_wdata),
        .en_set        (en_set),
        .take_maskable (take_maskable),
        .glb_en        (glb_en),
        .mask_q        (mask_q),
        .sod_q         (serial_out),
        .sw_clr_hi     (sw_clr_hi)
    );

    // Candidate gating: masks are bit 2 high, bit 1 middle, bit 0 low.
    always_comb begin
        cand          = '0;
        cand[SRC_NMI] = nmi_act;
        cand[SRC_HI]  = hi_pend     & ~mask_q[2] & glb_en;
        cand[SRC_MID] = lvl[SRC_MID] & ~mask_q[1] & glb_en;
        cand[SRC_LO]  = lvl[SRC_LO]  & ~mask_q[0] & glb_en;
        cand[SRC_EXT] = lvl[SRC_EXT] & glb_en;
    end

    assign take_maskable = |take[NSRC-1:1];

    irq_arbiter #(.N(NSRC)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (instr_boundary),
        .cand       (cand),
        .take       (take),
        .req_valid  (req_valid),
        .req_vector (req_vector),
        .intr_ack   (intr_ack)
    );

    // Read-mask value assembled from live state.
    assign mask_rdata = {serial_in, hi_pend, lvl[SRC_MID], lvl[SRC_LO], glb_en, mask_q};

endmodule

// File: rtl/irq_vector_chk.sv
// Module: irq_vector_chk
// Port-level properties of irq_vector_ctrl, attached by bind below.
module irq_vector_chk
    import irq_vec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             instr_boundary,
    input logic             en_set,
    input logic             mask_wr,
    input logic [7:0]       mask_wdata,
    input logic [7:0]       mask_rdata,
    input logic             serial_out,
    input logic             req_valid,
    input logic [VEC_W-1:0] req_vector,
    input logic             intr_ack
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && intr_ack)); // R9

    AST_RESULT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || intr_ack) |-> $past(instr_boundary)); // R13

    AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_ack || (req_valid && req_vector != VEC_NMI)) |-> !mask_rdata[3]); // R10

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[3]) |=> (mask_rdata[2:0] == $past(mask_wdata[2:0]))); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_wr && mask_wdata[3]) |=> $stable(mask_rdata[2:0])); // R3

    AST_SOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[6]) |=> (serial_out == $past(mask_wdata[7]))); // R4

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_vector == VEC_NMI || req_vector == VEC_HI ||
                       req_vector == VEC_MID || req_vector == VEC_LO)); // R7

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set && !instr_boundary) |=> mask_rdata[3]); // R11

endmodule

bind irq_vector_ctrl irq_vector_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_boundary (instr_boundary),
    .en_set         (en_set),
    .mask_wr        (mask_wr),
    .mask_wdata     (mask_wdata),
    .mask_rdata     (mask_rdata),
    .serial_out     (serial_out),
    .req_valid      (req_valid),
    .req_vector     (req_vector),
    .intr_ack       (intr_ack)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
    import irq_vec_pkg::*;

    localparam int SYNC = 2;
    localparam int SETTLE = SYNC + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 1'b0, irq_hi_pin = 1'b0, irq_mid_pin = 1'b0;
    logic        irq_lo_pin = 1'b0, ext_irq_pin = 1'b0;
    logic        instr_boundary = 1'b0, en_set = 1'b0, mask_wr = 1'b0;
    logic [7:0]  mask_wdata = 8'h00;
    logic        serial_in = 1'b0;
    logic [7:0]  mask_rdata;
    logic        serial_out, req_valid, intr_ack;
    logic [15:0] req_vector;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_hi_pin(irq_hi_pin),
        .irq_mid_pin(irq_mid_pin), .irq_lo_pin(irq_lo_pin), .ext_irq_pin(ext_irq_pin),
        .instr_boundary(instr_boundary), .en_set(en_set), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .serial_in(serial_in), .mask_rdata(mask_rdata),
        .serial_out(serial_out), .req_valid(req_valid), .req_vector(req_vector),
        .intr_ack(intr_ack)
    );

    typedef struct {
        logic        v;
        logic        a;
        logic [15:0] vec;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic bnd_seen = 1'b0;
    logic done = 1'b0;

    // Remember which cycles carry a boundary result.
    always @(posedge clk) bnd_seen <= instr_boundary;

    // Monitor: compare each boundary result against the scoreboard.
    always @(negedge clk) begin
        if (bnd_seen) begin
            if (expq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard empty: got v=%0b a=%0b vec=%h exp nothing queued",
                         req_valid, intr_ack, req_vector);
            end else begin
                exp_t e;
                e = expq.pop_front();
                n_cmp++;
                if (req_valid !== e.v || intr_ack !== e.a || (e.v && req_vector !== e.vec)) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b a=%0b vec=%h exp v=%0b a=%0b vec=%h",
                             e.tag, req_valid, intr_ack, req_vector, e.v, e.a, e.vec);
                end
            end
        end else if (rst_n && (req_valid || intr_ack)) begin
            n_cmp++; n_bad++;
            $display("FAIL R13 spurious result: got v=%0b a=%0b exp none", req_valid, intr_ack);
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // Driver: one boundary pulse with its predicted result queued.
    task automatic bnd(input logic v, input logic a, input logic [15:0] vec,
                       input string tag, input logic with_en);
        exp_t e;
        @(negedge clk);
        e.v = v; e.a = a; e.vec = vec; e.tag = tag;
        expq.push_back(e);
        instr_boundary = 1'b1;
        en_set = with_en;
        @(negedge clk);
        instr_boundary = 1'b0;
        en_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic mwr(input logic [7:0] d);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = d;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic ei();
        @(negedge clk); en_set = 1'b1;
        @(negedge clk); en_set = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_hi();
        @(negedge clk); irq_hi_pin = 1'b1;
        @(negedge clk); irq_hi_pin = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        settle(5);
        rst_n = 1'b1;
        settle(1);
        chk("R1 reset read value", mask_rdata, 8'h07);
        chk("R1 reset serial out", {7'b0, serial_out}, 8'h00);
        bnd(1'b0, 1'b0, 16'h0, "R1 nothing after reset", 1'b0);
        serial_in = 1'b1; settle(1);
        chk("R2 serial in bit 7", mask_rdata & 8'h80, 8'h80);
        serial_in = 1'b0;

        mwr(8'h0A);
        chk("R3 mask load", mask_rdata & 8'h07, 8'h02);
        mwr(8'h05);
        chk("R3 mask hold without load bit", mask_rdata & 8'h07, 8'h02);
        mwr(8'hC0);
        chk("R4 serial out load", {7'b0, serial_out}, 8'h01);
        mwr(8'h80);
        chk("R4 serial out hold", {7'b0, serial_out}, 8'h01);
        mwr(8'h40);
        chk("R4 serial out cleared", {7'b0, serial_out}, 8'h00);

        ei();
        chk("R11 enable set", mask_rdata & 8'h08, 8'h08);
        irq_mid_pin = 1'b1; settle(SETTLE);
        chk("R2 middle pending while masked", mask_rdata & 8'h70, 8'h20);
        bnd(1'b0, 1'b0, 16'h0, "R8 masked middle not taken", 1'b0);
        chk("R8 enable kept", mask_rdata & 8'h08, 8'h08);
        irq_lo_pin = 1'b1; settle(SETTLE);
        bnd(1'b1, 1'b0, VEC_LO, "R7 low vector", 1'b0);
        chk("R10 enable cleared by low", mask_rdata & 8'h08, 8'h00);
        bnd(1'b0, 1'b0, 16'h0, "R10 disabled after accept", 1'b0);
        irq_lo_pin = 1'b0; irq_mid_pin = 1'b0; settle(SETTLE);

        mwr(8'h08);
        pulse_hi(); settle(SETTLE);
        chk("R5 latch holds after pin falls", mask_rdata & 8'h40, 8'h40);
        bnd(1'b0, 1'b0, 16'h0, "R10 latch not taken while disabled", 1'b0);
        mwr(8'h10);
        chk("R5 software clear", mask_rdata & 8'h47, 8'h00);

        mwr(8'h0C);
        pulse_hi(); settle(SETTLE);
        chk("R5 edge caught while masked", mask_rdata & 8'h40, 8'h40);
        mwr(8'h08);
        ei();
        bnd(1'b1, 1'b0, VEC_HI, "R7 high vector", 1'b0);
        chk("R5 latch cleared by service", mask_rdata & 8'h48, 8'h00);

        ei();
        irq_mid_pin = 1'b1; irq_lo_pin = 1'b1; ext_irq_pin = 1'b1;
        pulse_hi(); settle(SETTLE);
        bnd(1'b1, 1'b0, VEC_HI, "R9 high over middle", 1'b0);
        ei();
        bnd(1'b1, 1'b0, VEC_MID, "R9 middle over low", 1'b0);
        ei();
        irq_mid_pin = 1'b0; settle(SETTLE);
        bnd(1'b1, 1'b0, VEC_LO, "R9 low over external", 1'b0);
        ei();
        irq_lo_pin = 1'b0; settle(SETTLE);
        bnd(1'b0, 1'b1, 16'h0, "R12 external acknowledge", 1'b0);
        ext_irq_pin = 1'b0; settle(SETTLE);

        ei();
        nmi_pin = 1'b1; settle(SETTLE);
        bnd(1'b1, 1'b0, VEC_NMI, "R6 non-maskable vector", 1'b0);
        chk("R10 non-maskable keeps enable", mask_rdata & 8'h08, 8'h08);
        bnd(1'b0, 1'b0, 16'h0, "R6 no retake while high", 1'b0);
        nmi_pin = 1'b0; settle(SETTLE);
        nmi_pin = 1'b1; settle(SETTLE);
        bnd(1'b1, 1'b0, VEC_NMI, "R6 retaken after new rise", 1'b0);
        nmi_pin = 1'b0; settle(SETTLE);
        nmi_pin = 1'b1; settle(SETTLE);
        nmi_pin = 1'b0; settle(SETTLE);
        bnd(1'b0, 1'b0, 16'h0, "R6 fall before service cancels", 1'b0);

        nmi_pin = 1'b1;
        pulse_hi(); settle(SETTLE);
        bnd(1'b1, 1'b0, VEC_NMI, "R9 non-maskable over high", 1'b0);
        bnd(1'b1, 1'b0, VEC_HI, "R9 high after non-maskable", 1'b0);
        nmi_pin = 1'b0; settle(SETTLE);

        ei();
        pulse_hi(); settle(SETTLE);
        bnd(1'b1, 1'b0, VEC_HI, "R10 accept with same-cycle enable", 1'b1);
        chk("R10 acceptance beats enable", mask_rdata & 8'h08, 8'h00);

        @(negedge clk); irq_hi_pin = 1'b1;
        @(negedge clk); irq_hi_pin = 1'b0;
        repeat (SYNC - 1) @(negedge clk);
        mask_wr = 1'b1; mask_wdata = 8'h10;
        @(negedge clk); mask_wr = 1'b0;
        settle(1);
        chk("R5 edge beats same-cycle clear", mask_rdata & 8'h40, 8'h40);
        mwr(8'h10);
        chk("R5 cleared afterwards", mask_rdata & 8'h40, 8'h00);

        ext_irq_pin = 1'b1;
        ei();
        settle(6);
        chk("R13 no boundary keeps enable", mask_rdata & 8'h08, 8'h08);
        bnd(1'b0, 1'b1, 16'h0, "R12 acknowledge at boundary", 1'b0);
        ext_irq_pin = 1'b0;
        settle(SETTLE);
        chk("R13 scoreboard drained", 8'(expq.size()), 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule